// File: doc/BRIEF.md
# DMA Channel Control and Status Unit

This block holds the software-visible control and status state of a single DMA channel. Software programs a transfer mode and four per-cause interrupt enables through a control word. It starts and halts the channel through an operation word. It reads back sticky completion and fault causes from a status word. The datapath reports events as single-cycle pulses: done from the subsystem, last link processed, host access error and total-count reached. It also drives a level that says whether a link is ready. The block returns a running flag, the selected mode and one level interrupt.

Run control is a two-state machine. In `ST_STOPPED`, transition `GO` is taken on a START write that carries no STOP bit and leads to `ST_RUNNING`. In `ST_RUNNING`, transition `HALT_SW` (a STOP write) and transition `HALT_EV` (a done, last-link or error pulse) both lead back to `ST_STOPPED`. All other inputs hold the current state.

Status causes can be cleared three ways: by a START that takes effect, by a read at the volatile status offset, or by writing 0 to the matching enable. If a cause is set in the same cycle that it is cleared, the set wins, so no event is lost.

Top module: `dma_chan_csr`

## Requirements
- R1: Control word (offset 0x54) bits [1:0] hold the mode and drive `chan_mode` from the cycle after the write: 1 is normal mode and 2 is link-chain mode. Bits [7:4] hold the notify enables in the order done, total-count, last-link, error. A control read returns these fields and 0 elsewhere. Reset sets mode 0 and all enables to 0.
- R2: Writing the operation word (offset 0x58) with bit 0 set and bit 1 clear runs the channel and clears all four status causes. The clear also happens when the channel is already running.
- R3: Writing the operation word with bit 1 set halts the channel and sets Done. It wins over bit 0 in the same write, and no clearing takes place.
- R4: An operation-word read returns the running flag in bit 0 and its inverse in bit 1.
- R5: While the channel runs, a done, last-link or error pulse sets its status bit and halts the channel. A total-count pulse sets its bit and leaves the channel running.
- R6: Event pulses have no effect while the channel is stopped.
- R7: Writing a 0 to a notify enable clears the matching status cause.
- R8: The status word (offset 0x60) and the volatile status word (offset 0x68) share one layout: bits [16:13] are done, total-count, last-link and error. A volatile read returns the current value and then clears all four causes. A read of the normal status word clears nothing.
- R9: `irq` and status bit 18 are 1 exactly while some cause is set and enabled. `irq` is a level output. Status bit 17 always reads 0.
- R10: Status bits [11:0] return the stream number parameter, and bit 12 follows the link-ready input.
- R11: After reset the channel is stopped, all causes are clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| ev_done | input | 1 | Done pulse from the subsystem |
| ev_last_link | input | 1 | Last link processed pulse |
| ev_error | input | 1 | Host access error pulse |
| ev_total_count | input | 1 | Total-count reached pulse |
| ev_link_ready | input | 1 | Link-ready level |
| chan_running | output | 1 | Channel running flag |
| chan_mode | output | 2 | Selected mode |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check every cycle that STOP wins over START, that a lone START leads to running, and that a halting event stops a running channel. They also check that a stopped channel with an idle bus keeps `irq` steady, that a volatile read on an idle stopped channel leaves `irq` low, that the operation read bits are inverses of each other, and that the mode follows a control write. Only the bench scenarios can show how each cause combines with each of the sixteen enable patterns. The same holds for the full status word before and after a volatile read, the fact that a normal read does not clear, and the clearing done by an enable write or by a START on a channel that is already running.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    localparam int CAUSES  = 4;
    localparam int CZ_DONE = 0;
    localparam int CZ_TC   = 1;
    localparam int CZ_LAST = 2;
    localparam int CZ_ERR  = 3;

    localparam int MODE_W      = 2;
    localparam int CTL_EN_LSB  = 4;
    localparam int OP_START    = 0;
    localparam int OP_STOP     = 1;
    localparam int STS_LINK    = 12;
    localparam int STS_CZ_LSB  = 13;
    localparam int STS_ADDL    = 17;
    localparam int STS_INT     = 18;

    localparam logic [MODE_W-1:0] MODE_NORMAL = 2'd1;
    localparam logic [MODE_W-1:0] MODE_LINK   = 2'd2;

endpackage

// File: rtl/dma_run_fsm.sv
module dma_run_fsm
    import dma_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic halt_sw,
    input  logic halt_ev,
    output logic running
);

    run_state_e state_q;
    run_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (go && !halt_sw) state_d = ST_RUNNING;   // GO
            ST_RUNNING: if (halt_sw || halt_ev) state_d = ST_STOPPED; // HALT_SW / HALT_EV
            default:    state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUNNING);
    end

endmodule

// File: rtl/dma_cause_bank.sv
module dma_cause_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] stat
);

    for (genvar i = 0; i < N; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (!rst_n) stat[i] <= 1'b0;
            else        stat[i] <= (stat[i] & ~clr_vec[i]) | set_vec[i];
        end
    end

endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import dma_csr_pkg::*;
#(
    parameter int DW = 32,
    parameter int N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    output logic [MODE_W-1:0] mode,
    output logic [N-1:0]      en,
    output logic [N-1:0]      en_clr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            en   <= '0;
        end else if (wr_en) begin
            mode <= wdata[MODE_W-1:0];
            en   <= wdata[CTL_EN_LSB +: N];
        end
    end

    assign en_clr = wr_en ? ~wdata[CTL_EN_LSB +: N] : '0;

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
    import dma_csr_pkg::*;
#(
    parameter int              AW        = 8,
    parameter int              DW        = 32,
    parameter int              N         = 4,
    parameter int              SW        = 12,
    parameter logic [SW-1:0]   STREAM_ID = '0,
    parameter logic [AW-1:0]   A_CTL     = 8'h54,
    parameter logic [AW-1:0]   A_OP      = 8'h58,
    parameter logic [AW-1:0]   A_STS     = 8'h60,
    parameter logic [AW-1:0]   A_VSTS    = 8'h68
) (
    input  logic [AW-1:0]     addr,
    input  logic [MODE_W-1:0] mode,
    input  logic [N-1:0]      en,
    input  logic [N-1:0]      stat,
    input  logic              running,
    input  logic              link_ready,
    input  logic              irq,
    output logic [DW-1:0]     rdata
);

    always_comb begin
        rdata = '0;
        if (addr == A_CTL) begin
            rdata[MODE_W-1:0]       = mode;
            rdata[CTL_EN_LSB +: N]  = en;
        end else if (addr == A_OP) begin
            rdata[OP_START] = running;
            rdata[OP_STOP]  = !running;
        end else if (addr == A_STS || addr == A_VSTS) begin
            rdata[SW-1:0]          = STREAM_ID;
            rdata[STS_LINK]        = link_ready;
            rdata[STS_CZ_LSB +: N] = stat;
            rdata[STS_ADDL]        = 1'b0;
            rdata[STS_INT]         = irq;
        end
    end

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 32,
    parameter int            SW        = 12,
    parameter logic [SW-1:0] STREAM_ID = 12'h3C5,
    parameter logic [AW-1:0] A_CTL     = 8'h54,
    parameter logic [AW-1:0] A_OP      = 8'h58,
    parameter logic [AW-1:0] A_STS     = 8'h60,
    parameter logic [AW-1:0] A_VSTS    = 8'h68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ev_done,
    input  logic          ev_last_link,
    input  logic          ev_error,
    input  logic          ev_total_count,
    input  logic          ev_link_ready,
    output logic          chan_running,
    output logic [1:0]    chan_mode,
    output logic          irq
);

    localparam int N = CAUSES;

    logic         ctl_wr, op_wr, vol_rd;
    logic         start_bit, stop_bit, go_eff;
    logic [N-1:0] en, stat, en_clr, set_vec, clr_vec, ev_vec;

    assign ctl_wr    = reg_wr && (reg_addr == A_CTL);
    assign op_wr     = reg_wr && (reg_addr == A_OP);
    assign vol_rd    = reg_rd && (reg_addr == A_VSTS);
    assign start_bit = op_wr && reg_wdata[OP_START];
    assign stop_bit  = op_wr && reg_wdata[OP_STOP];
    assign go_eff    = start_bit && !stop_bit;

    always_comb begin
        ev_vec          = '0;
        ev_vec[CZ_DONE] = ev_done;
        ev_vec[CZ_TC]   = ev_total_count;
        ev_vec[CZ_LAST] = ev_last_link;
        ev_vec[CZ_ERR]  = ev_error;
        set_vec          = chan_running ? ev_vec : '0;
        set_vec[CZ_DONE] = set_vec[CZ_DONE] | stop_bit;
        clr_vec          = en_clr | ((go_eff || vol_rd) ? {N{1'b1}} : '0);
    end

    dma_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (start_bit),
        .halt_sw (stop_bit),
        .halt_ev (ev_done || ev_last_link || ev_error),
        .running (chan_running)
    );

    dma_ctl_reg #(.DW(DW), .N(N)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctl_wr),
        .wdata  (reg_wdata),
        .mode   (chan_mode),
        .en     (en),
        .en_clr (en_clr)
    );

    dma_cause_bank #(.N(N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat    (stat)
    );

    assign irq = |(stat & en);

    dma_read_mux #(
        .AW(AW), .DW(DW), .N(N), .SW(SW), .STREAM_ID(STREAM_ID),
        .A_CTL(A_CTL), .A_OP(A_OP), .A_STS(A_STS), .A_VSTS(A_VSTS)
    ) u_rmux (
        .addr       (reg_addr),
        .mode       (chan_mode),
        .en         (en),
        .stat       (stat),
        .running    (chan_running),
        .link_ready (ev_link_ready),
        .irq        (irq),
        .rdata      (reg_rdata)
    );

endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
    parameter int            AW     = 8,
    parameter int            DW     = 32,
    parameter logic [AW-1:0] A_CTL  = 8'h54,
    parameter logic [AW-1:0] A_OP   = 8'h58,
    parameter logic [AW-1:0] A_STS  = 8'h60,
    parameter logic [AW-1:0] A_VSTS = 8'h68
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          ev_done,
    input logic          ev_last_link,
    input logic          ev_error,
    input logic          chan_running,
    input logic [1:0]    chan_mode,
    input logic          irq
);

    assert_mode_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTL) |=> (chan_mode == $past(reg_wdata[1:0])));

    assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_OP && reg_wdata[0] && !reg_wdata[1]) |=> chan_running);

    assert_stop_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_OP && reg_wdata[1]) |=> !chan_running);

    assert_op_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_OP) |-> (reg_rdata[1] != reg_rdata[0]));

    assert_event_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_running && (ev_done || ev_last_link || ev_error) &&
         !(reg_wr && reg_addr == A_OP)) |=> !chan_running);

    assert_idle_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_running && !reg_wr && !reg_rd) |=> ($stable(irq) && !chan_running));

    assert_volatile_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_VSTS && !chan_running && !reg_wr) |=> !irq);

    assert_int_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == A_STS || reg_addr == A_VSTS)) |->
        (!reg_rdata[17] && reg_rdata[18] == irq));

endmodule

bind dma_chan_csr dma_chan_csr_chk #(
    .AW(AW), .DW(DW), .A_CTL(A_CTL), .A_OP(A_OP), .A_STS(A_STS), .A_VSTS(A_VSTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ev_done      (ev_done),
    .ev_last_link (ev_last_link),
    .ev_error     (ev_error),
    .chan_running (chan_running),
    .chan_mode    (chan_mode),
    .irq          (irq)
);

// File: tb/sim_dma_chan_csr.sv
`timescale 1ns/1ps
module sim_dma_chan_csr;

    localparam logic [11:0] SID    = 12'h3C5;
    localparam logic [7:0]  A_CTL  = 8'h54;
    localparam logic [7:0]  A_OP   = 8'h58;
    localparam logic [7:0]  A_STS  = 8'h60;
    localparam logic [7:0]  A_VSTS = 8'h68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_done = 0, ev_last_link = 0, ev_error = 0, ev_total_count = 0, ev_link_ready = 0;
    logic        chan_running, irq;
    logic [1:0]  chan_mode;

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench model: cause order done, total-count, last-link, error
    logic       m_run = 0;
    logic [3:0] m_st = 0, m_en = 0;
    logic [1:0] m_mode = 0;

    always #5 clk = ~clk;

    dma_chan_csr u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_done(ev_done), .ev_last_link(ev_last_link), .ev_error(ev_error),
        .ev_total_count(ev_total_count), .ev_link_ready(ev_link_ready),
        .chan_running(chan_running), .chan_mode(chan_mode), .irq(irq)
    );

    function automatic logic [31:0] exp_sts();
        logic [31:0] w = '0;
        w[11:0]  = SID;
        w[12]    = ev_link_ready;
        w[16:13] = m_st;
        w[18]    = |(m_st & m_en);
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
        if (a == A_CTL) begin m_mode = d[1:0]; m_en = d[7:4]; m_st &= d[7:4]; end
        if (a == A_OP) begin
            if (d[1]) begin m_run = 0; m_st[0] = 1; end
            else if (d[0]) begin m_run = 1; m_st = 0; end
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 0;
        if (a == A_VSTS) m_st = 0;
    endtask

    task automatic pulse(logic [3:0] m);
        @(negedge clk);
        {ev_error, ev_last_link, ev_total_count, ev_done} = m;
        @(posedge clk); #1;
        {ev_error, ev_last_link, ev_total_count, ev_done} = 4'b0;
        if (m_run) begin
            m_st |= m;
            if (m[0] || m[2] || m[3]) m_run = 0;
        end
    endtask

    task automatic check_outputs(string req);
        chk({req, " running"}, {31'b0, chan_running}, {31'b0, m_run});
        chk({req, " irq"}, {31'b0, irq}, {31'b0, |(m_st & m_en)});
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R11 reset state
        check_outputs("R11");
        rd(A_OP, d);   chk("R11 op", d, 32'h2);
        rd(A_STS, d);  chk("R11 status", d, exp_sts());
        rd(A_CTL, d);  chk("R11 ctl", d, 32'h0);

        // R1 mode and enables
        wr(A_CTL, {24'b0, 4'b1010, 2'b0, 2'd2});
        chk("R1 mode link", {30'b0, chan_mode}, 32'd2);
        rd(A_CTL, d);  chk("R1 ctl read", d, 32'h000000A2);
        wr(A_CTL, {24'b0, 4'b0000, 2'b0, 2'd1});
        chk("R1 mode normal", {30'b0, chan_mode}, 32'd1);

        // R6 events while stopped
        wr(A_CTL, 32'h000000F1);
        pulse(4'hF);
        check_outputs("R6");
        rd(A_STS, d);  chk("R6 status", d, exp_sts());

        // R10 link ready and stream
        ev_link_ready = 1;
        rd(A_STS, d);  chk("R10 link ready", d, exp_sts());
        ev_link_ready = 0;
        rd(A_STS, d);  chk("R10 link low", d, exp_sts());

        // R3 stop wins over start, sets done
        wr(A_OP, 32'h3);
        check_outputs("R3 both");
        rd(A_STS, d);  chk("R3 done set", d, exp_sts());
        rd(A_OP, d);   chk("R4 stopped", d, 32'h2);

        // R2 start clears, R4 running read
        wr(A_OP, 32'h1);
        check_outputs("R2 start");
        rd(A_OP, d);   chk("R4 running", d, 32'h1);
        pulse(4'b0010);
        check_outputs("R5 tc keeps run");
        wr(A_OP, 32'h1);
        check_outputs("R2 restart clears");
        rd(A_STS, d);  chk("R2 status", d, exp_sts());

        // R7 enable clear
        pulse(4'b0010);
        wr(A_CTL, 32'h000000D1);
        check_outputs("R7 clear tc");
        rd(A_STS, d);  chk("R7 status", d, exp_sts());

        // R3 stop while running
        wr(A_OP, 32'h2);
        check_outputs("R3 stop");
        rd(A_VSTS, d); chk("R8 vol read", d, 32'h0 | {13'b0, 1'b0, 4'b0001, 1'b0, SID} | 32'h40000);
        check_outputs("R8 after vol");

        // sweep enables x causes
        for (int en = 0; en < 16; en++) begin
            for (int c = 0; c < 4; c++) begin
                wr(A_CTL, {24'b0, en[3:0], 4'h1});
                wr(A_OP, 32'h1);
                pulse(4'b1 << c);
                check_outputs("R5 R9 sweep");
                rd(A_STS, d);  chk("R8 R9 normal", d, exp_sts());
                rd(A_STS, d);  chk("R8 no clear", d, exp_sts());
                rd(A_VSTS, d); chk("R8 vol value", d[16:13], {28'b0, 4'b1 << c});
                rd(A_STS, d);  chk("R8 cleared", d, exp_sts());
                check_outputs("R9 after clear");
                if (m_run) wr(A_OP, 32'h2);
                rd(A_VSTS, d);
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule